// File: doc/BRIEF.md
# Power Mode Transition Controller

This block sequences one switchable memory power domain between three operating modes: fully on (every bank active), partial retention (selected banks held at a reduced supply) and fully off. A request port carries the wanted mode. The block checks each request against a fixed table of permitted moves. If the move is not permitted, the block raises a one-cycle error and changes nothing. If it is permitted, the block drives its power-management outputs in a fixed order. These outputs are the clock gate, the isolation enable, the retention save and restore strobes, and two sleep lines that feed the header switch.

The settle time of the supply is modelled as a wait counted in clock cycles. The count comes from `settle_cycles_i`, and the block holds it after every change on the sleep lines. While isolation is asserted, the domain's outgoing data is clamped to a selectable constant. The polarity of the isolation enable can also be selected.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is active and after it is released, the block rests in fully off: `mode_o`=2, isolation asserted, both sleep lines high, `clk_en_o` low, `busy_o` low, no strobes and no error.
- R2: Mode codes are 0 = fully on, 1 = partial retention, 2 = fully off and 3 = invalid. An idle request for on→off, for off→retention or for code 3 pulses `err_o` high for exactly one cycle, starting one cycle after the sampling edge. The mode and all outputs stay unchanged.
- R3: An idle request for the mode already held leaves `busy_o` low, gives no error and changes no output.
- R4: A request sampled while `busy_o` is high pulses `err_o` one cycle later and does not alter the sequence in progress.
- R5: The on→retention move, with N = `settle_cycles_i`, runs as follows. Edge E0 lowers `clk_en_o`. E1 asserts isolation. E2 raises `save_o` for one cycle. E3 raises `sleep_a_o`. E(4+N) sets `mode_o`=1 and drops `busy_o`.
- R6: The retention→on move runs as follows. E0 lowers `sleep_a_o`. E(1+N) raises `restore_o` for one cycle. E(2+N) releases isolation. E(3+N) raises `clk_en_o`, sets `mode_o`=0 and drops `busy_o`.
- R7: The off→on move runs as follows. E0 lowers both sleep lines. E(1+N) releases isolation, with no restore strobe. E(2+N) raises `clk_en_o` and completes the move.
- R8: The retention→off move raises only `sleep_b_o` at E0. It completes at E(1+N) with `mode_o`=2.
- R9: `clk_en_o` is high only when both sleep lines are low and isolation is released.
- R10: Any two changes of the sleep lines are at least N+1 cycles apart.
- R11: `iso_o` equals the logical isolation state XOR `iso_active_low_i`. While isolation is asserted, every bit of `dom_data_o` equals `clamp_val_i`; otherwise `dom_data_o` follows `dom_data_i`.
- R12: `save_o` and `restore_o` are single-cycle strobes. They occur only while isolation is asserted and `clk_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe, sampled on each rising edge |
| req_mode_i | input | 2 | Requested mode code |
| settle_cycles_i | input | CNT_W | Supply settle wait N in cycles |
| iso_active_low_i | input | 1 | 1 selects an active-low isolation enable |
| clamp_val_i | input | 1 | Clamp constant for isolated data |
| dom_data_i | input | DATA_W | Data leaving the domain |
| dom_data_o | output | DATA_W | Data after the isolation clamp |
| iso_o | output | 1 | Isolation enable, with the selected polarity |
| save_o | output | 1 | Retention save strobe |
| restore_o | output | 1 | Retention restore strobe |
| sleep_a_o | output | 1 | Header sleep line A (high = off) |
| sleep_b_o | output | 1 | Header sleep line B (high = off) |
| clk_en_o | output | 1 | Domain clock enable |
| mode_o | output | 2 | Current mode code |
| busy_o | output | 1 | A transition is in progress |
| err_o | output | 1 | Rejected-request pulse |

## Verification
All registered results are due at fixed edges counted from the request's sampling edge E0. The error flag follows one edge later. Each sequence step lands at its own edge, E0 through E(4+N), as the requirements give it. The clamp and the isolation polarity act combinationally in the same cycle. The bench builds the expected output vector for each future edge from the requested move and the sampled N, and queues it. At every falling clock edge it compares the whole output set, so every step is checked in exactly the cycle it is due.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_ON  = 2'd0,
    MODE_RET = 2'd1,
    MODE_OFF = 2'd2,
    MODE_BAD = 2'd3
  } pmc_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISO_ON,
    ST_SAVE,
    ST_SLEEP_DN,
    ST_WAIT,
    ST_ISO_OFF,
    ST_CLK_ON
  } pmc_state_e;
endpackage

// File: rtl/pmc_legal_chk.sv
module pmc_legal_chk
  import pmc_pkg::*;
(
  input  pmc_mode_e   cur_mode_i,
  input  logic [1:0]  req_mode_i,
  output logic        legal_o,
  output logic        noop_o
);
  always_comb begin
    legal_o = 1'b0;
    unique case ({cur_mode_i, req_mode_i})
      {MODE_ON,  2'd1},
      {MODE_RET, 2'd0},
      {MODE_RET, 2'd2},
      {MODE_OFF, 2'd0}: legal_o = 1'b1;
      default:          legal_o = 1'b0;
    endcase
  end

  assign noop_o = (req_mode_i == cur_mode_i);
endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pmc_iso_clamp.sv
module pmc_iso_clamp #(
  parameter int DATA_W = 16
) (
  input  logic              iso_i,
  input  logic              clamp_val_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign data_o[b] = iso_i ? clamp_val_i : data_i[b];
  end
endmodule

// File: rtl/pmc_sequencer.sv
module pmc_sequencer
  import pmc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [1:0]       req_mode_i,
  input  logic             legal_i,
  input  logic             noop_i,
  input  logic [CNT_W-1:0] settle_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output pmc_mode_e        mode_o,
  output logic             busy_o,
  output logic             err_o,
  output logic             iso_o,
  output logic             save_o,
  output logic             restore_o,
  output logic             sleep_a_o,
  output logic             sleep_b_o,
  output logic             clk_en_o
);
  pmc_state_e st_q, st_d;
  pmc_mode_e  mode_q, mode_d, tgt_q, tgt_d;
  logic up_q, up_d, rflag_q, rflag_d;
  logic iso_q, iso_d, save_q, save_d, rst_q, rst_d;
  logic sa_q, sa_d, sb_q, sb_d, clk_q, clk_d, err_q, err_d;
  logic [CNT_W-1:0] gap_q;

  assign busy_o = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;  mode_d = mode_q; tgt_d = tgt_q;
    up_d = up_q;  rflag_d = rflag_q;
    iso_d = iso_q; save_d = 1'b0; rst_d = 1'b0;
    sa_d = sa_q;  sb_d = sb_q; clk_d = clk_q;
    tmr_load_o = 1'b0;
    err_d = req_valid_i && (busy_o || (!legal_i && !noop_i));
    unique case (st_q)
      ST_IDLE: if (req_valid_i && legal_i) begin
        tgt_d = pmc_mode_e'(req_mode_i);
        if (mode_q == MODE_ON) begin
          clk_d = 1'b0;
          st_d  = ST_ISO_ON;
        end else if (mode_q == MODE_RET && req_mode_i == 2'd0) begin
          sa_d = 1'b0; tmr_load_o = 1'b1; up_d = 1'b1; rflag_d = 1'b1;
          st_d = ST_WAIT;
        end else if (mode_q == MODE_RET) begin
          sb_d = 1'b1; tmr_load_o = 1'b1; up_d = 1'b0;
          st_d = ST_WAIT;
        end else begin
          sa_d = 1'b0; sb_d = 1'b0; tmr_load_o = 1'b1;
          up_d = 1'b1; rflag_d = 1'b0;
          st_d = ST_WAIT;
        end
      end
      ST_ISO_ON: begin iso_d = 1'b1; st_d = ST_SAVE; end
      ST_SAVE:   begin save_d = 1'b1; st_d = ST_SLEEP_DN; end
      ST_SLEEP_DN: begin
        sa_d = 1'b1; tmr_load_o = 1'b1; up_d = 1'b0;
        st_d = ST_WAIT;
      end
      ST_WAIT: if (tmr_done_i) begin
        if (!up_q) begin
          mode_d = tgt_q; st_d = ST_IDLE;
        end else if (rflag_q) begin
          rst_d = 1'b1; st_d = ST_ISO_OFF;
        end else begin
          iso_d = 1'b0; st_d = ST_CLK_ON;
        end
      end
      ST_ISO_OFF: begin iso_d = 1'b0; st_d = ST_CLK_ON; end
      ST_CLK_ON: begin clk_d = 1'b1; mode_d = tgt_q; st_d = ST_IDLE; end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; mode_q <= MODE_OFF; tgt_q <= MODE_OFF;
      up_q <= 1'b0; rflag_q <= 1'b0;
      iso_q <= 1'b1; save_q <= 1'b0; rst_q <= 1'b0;
      sa_q <= 1'b1; sb_q <= 1'b1; clk_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_d; mode_q <= mode_d; tgt_q <= tgt_d;
      up_q <= up_d; rflag_q <= rflag_d;
      iso_q <= iso_d; save_q <= save_d; rst_q <= rst_d;
      sa_q <= sa_d; sb_q <= sb_d; clk_q <= clk_d; err_q <= err_d;
    end
  end

  // cycles since the last sleep-line change, for the spacing check only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          gap_q <= '1;
    else if (sa_d != sa_q || sb_d != sb_q) gap_q <= '0;
    else if (gap_q != '1)                  gap_q <= gap_q + 1'b1;
  end

  assign mode_o = mode_q;  assign err_o = err_q;   assign iso_o = iso_q;
  assign save_o = save_q;  assign restore_o = rst_q;
  assign sleep_a_o = sa_q; assign sleep_b_o = sb_q; assign clk_en_o = clk_q;

  // R9
  clk_on_pwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> (!sleep_a_o && !sleep_b_o && !iso_o));
  // R10
  sleep_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sa_d != sa_q || sb_d != sb_q) |-> (gap_q >= settle_i));
  // R12
  save_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    save_o |=> !save_o);
  // R12
  restore_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_o |=> !restore_o);
  // R12
  strobe_safe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_o || restore_o) |-> (iso_o && !clk_en_o));
  // R8
  off_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_b_o) |-> sleep_a_o);
  // R4
  busy_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && busy_o) |=> (err_o && busy_o == $past(st_d != ST_IDLE)));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_mode_i,
  input  logic [CNT_W-1:0]  settle_cycles_i,
  input  logic              iso_active_low_i,
  input  logic              clamp_val_i,
  input  logic [DATA_W-1:0] dom_data_i,
  output logic [DATA_W-1:0] dom_data_o,
  output logic              iso_o,
  output logic              save_o,
  output logic              restore_o,
  output logic              sleep_a_o,
  output logic              sleep_b_o,
  output logic              clk_en_o,
  output logic [1:0]        mode_o,
  output logic              busy_o,
  output logic              err_o
);
  pmc_mode_e mode_w;
  logic legal_w, noop_w, tmr_load_w, tmr_done_w, iso_w;

  pmc_legal_chk u_legal (
    .cur_mode_i (mode_w),
    .req_mode_i (req_mode_i),
    .legal_o    (legal_w),
    .noop_o     (noop_w)
  );

  pmc_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load_w),
    .load_val_i (settle_cycles_i),
    .done_o     (tmr_done_w)
  );

  pmc_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_mode_i  (req_mode_i),
    .legal_i     (legal_w),
    .noop_i      (noop_w),
    .settle_i    (settle_cycles_i),
    .tmr_done_i  (tmr_done_w),
    .tmr_load_o  (tmr_load_w),
    .mode_o      (mode_w),
    .busy_o      (busy_o),
    .err_o       (err_o),
    .iso_o       (iso_w),
    .save_o      (save_o),
    .restore_o   (restore_o),
    .sleep_a_o   (sleep_a_o),
    .sleep_b_o   (sleep_b_o),
    .clk_en_o    (clk_en_o)
  );

  pmc_iso_clamp #(.DATA_W(DATA_W)) u_clamp (
    .iso_i       (iso_w),
    .clamp_val_i (clamp_val_i),
    .data_i      (dom_data_i),
    .data_o      (dom_data_o)
  );

  assign iso_o  = iso_w ^ iso_active_low_i;
  assign mode_o = mode_w;

  // R2
  illegal_rej_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && !legal_w && !noop_w) |=> (err_o && !busy_o && $stable(mode_o)));
  // R3
  noop_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && noop_w) |=> (!err_o && !busy_o && $stable(mode_o)));
  // R2
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !$past(req_valid_i)) |-> 1'b0);
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
module pwr_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 16;

  typedef struct packed {
    logic [1:0] mode;
    logic busy, iso, save, rst, sa, sb, clk;
  } snap_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic [CNT_W-1:0] settle = 8'd3;
  logic pol = 1'b0, clamp = 1'b0;
  logic [DATA_W-1:0] din = 16'h1234, dout;
  logic iso_o, save_o, restore_o, sa_o, sb_o, clk_en_o, busy_o, err_o;
  logic [1:0] mode_o;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  string tag = "R1";
  snap_t exp_s, q[$];
  logic exp_err = 1'b0;
  localparam snap_t RST_S = '{mode: 2'd2, busy: 0, iso: 1, save: 0, rst: 0, sa: 1, sb: 1, clk: 0};

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_mode_i(req_mode),
    .settle_cycles_i(settle), .iso_active_low_i(pol), .clamp_val_i(clamp),
    .dom_data_i(din), .dom_data_o(dout), .iso_o(iso_o), .save_o(save_o),
    .restore_o(restore_o), .sleep_a_o(sa_o), .sleep_b_o(sb_o), .clk_en_o(clk_en_o),
    .mode_o(mode_o), .busy_o(busy_o), .err_o(err_o)
  );

  task automatic chk(string what, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
    end
  endtask

  // permitted moves (R2)
  function automatic bit permitted(logic [1:0] from, logic [1:0] to);
    return (from == 2'd0 && to == 2'd1) || (from == 2'd1 && to == 2'd0) ||
           (from == 2'd1 && to == 2'd2) || (from == 2'd2 && to == 2'd0);
  endfunction

  // queue the expected state after each edge E0.. of an accepted move
  task automatic plan(snap_t b, logic [1:0] to, int n);
    snap_t v = b;
    v.busy = 1; v.save = 0; v.rst = 0;
    if (b.mode == 2'd0) begin                       // R5
      v.clk = 0; q.push_back(v);
      v.iso = 1; q.push_back(v);
      v.save = 1; q.push_back(v);
      v.save = 0; v.sa = 1; q.push_back(v);
      for (int i = 0; i < n; i++) q.push_back(v);
      v.mode = 2'd1; v.busy = 0; q.push_back(v);
    end else if (b.mode == 2'd1 && to == 2'd0) begin // R6
      v.sa = 0; q.push_back(v);
      for (int i = 0; i < n; i++) q.push_back(v);
      v.rst = 1; q.push_back(v);
      v.rst = 0; v.iso = 0; q.push_back(v);
      v.clk = 1; v.mode = 2'd0; v.busy = 0; q.push_back(v);
    end else if (b.mode == 2'd1) begin              // R8
      v.sb = 1; q.push_back(v);
      for (int i = 0; i < n; i++) q.push_back(v);
      v.mode = 2'd2; v.busy = 0; q.push_back(v);
    end else begin                                  // R7
      v.sa = 0; v.sb = 0; q.push_back(v);
      for (int i = 0; i < n; i++) q.push_back(v);
      v.iso = 0; q.push_back(v);
      v.clk = 1; v.mode = 2'd0; v.busy = 0; q.push_back(v);
    end
  endtask

  always @(negedge clk) begin
    snap_t a, e, nx;
    a = '{mode: mode_o, busy: busy_o, iso: iso_o, save: save_o, rst: restore_o,
          sa: sa_o, sb: sb_o, clk: clk_en_o};
    e = rst_n ? exp_s : RST_S;
    e.iso = e.iso ^ pol;                             // R11 polarity
    chk("outputs", 32'(a), 32'(e));
    chk("err", 32'(err_o), rst_n ? 32'(exp_err) : 32'd0);
    chk("data", 32'(dout), (rst_n ? exp_s.iso : 1'b1) ? {DATA_W{clamp}} : 32'(din)); // R11
    if (!rst_n) begin
      exp_s = RST_S; exp_err = 1'b0; q.delete();
    end else begin
      exp_err = req_valid && (exp_s.busy || (!permitted(exp_s.mode, req_mode) && req_mode != exp_s.mode));
      if (q.size() == 0 && req_valid && !exp_s.busy && permitted(exp_s.mode, req_mode))
        plan(exp_s, req_mode, int'(settle));
      if (q.size() > 0) nx = q.pop_front();
      else begin nx = exp_s; nx.save = 0; nx.rst = 0; end
      exp_s = nx;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      din = {din[14:0], din[15] ^ din[13]} + 16'h0101;
    end
  endtask

  task automatic request(logic [1:0] m);
    @(posedge clk); #1; req_valid = 1'b1; req_mode = m;
    @(posedge clk); #1; req_valid = 1'b0;
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);                                         // R1 reset state held
    tag = "R2"; request(2'd1); tick(12);             // off->retention rejected
    tag = "R2"; request(2'd3); tick(12);             // invalid code
    tag = "R3"; request(2'd2); tick(12);             // off->off no-op
    tag = "R7"; settle = 8'd3; request(2'd0); tick(20);
    tag = "R3"; request(2'd0); tick(12);
    tag = "R2"; request(2'd2); tick(12);             // on->off rejected
    tag = "R5/R12"; settle = 8'd2; request(2'd1);
    tag = "R4"; request(2'd0); tick(20);             // ignored while busy
    tag = "R8"; settle = 8'd0; request(2'd2); tick(12);
    tag = "R7/R9"; settle = 8'd1; request(2'd0); tick(12);
    tag = "R11"; pol = 1'b1; clamp = 1'b1; tick(12);
    tag = "R5/R11"; settle = 8'd5; request(2'd1); tick(20);
    tag = "R6/R10"; settle = 8'd4; request(2'd0); tick(20);
    tag = "R11"; clamp = 1'b0; settle = 8'd1; request(2'd1); tick(20);
    tag = "R8/R10"; request(2'd2); tick(20);
    tag = "R4"; settle = 8'd2; request(2'd0); request(2'd2); request(2'd1); tick(20);
    tag = "R12"; request(2'd1); tick(12); request(2'd0); tick(12);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule